// File: doc/BRIEF.md
# Programmable Line-End Pulse Generator

This block drives the line-end strobe of a display panel. The horizontal timing logic sends it a one-cycle indication when the last panel clock of an active line rises. The block then counts a programmable number of controller clock periods and issues a single-cycle strobe. One 32-bit control word holds the delay setting and an enable. While the enable is clear, the strobe output stays low.

The delay is programmed as "periods minus one", so a setting of N gives N+1 controller clocks. The counter latches the setting when an event starts. Later writes therefore change only events that begin after them. A fresh event that arrives while a count is running restarts the count. Clearing the enable drops any pending strobe. Software reads the control word back through the same register port.

Top module: `line_end_gen`

## Requirements
- R1: After reset the delay field and the enable read as 0, `reg_rdata` is 0 and `line_end` is low.
- R2: A write with `reg_we` high stores `reg_wdata[6:0]` as the delay setting and `reg_wdata[16]` as the enable. `reg_rdata` returns both at the same bit positions in the cycle after the write edge.
- R3: Writes to bits 31:17 and 15:7 have no effect, and those bits always read 0. Writing all ones reads back 0x0001007F.
- R4: Let `panel_last_edge` be sampled high at clock edge k while enabled, with setting N. Then `line_end` goes high after edge k+N+1, which is N+1 controller clocks later.
- R5: Each completed count raises `line_end` for exactly one controller clock period.
- R6: While the enable is 0, `line_end` is held low and `panel_last_edge` is ignored. An event sampled at the same edge that sets the enable is also ignored.
- R7: If a new event is sampled while a count is still running, the count restarts from that event with the current setting. The earlier count produces no strobe.
- R8: Clearing the enable while a count runs cancels it. `line_end` stays low from the write edge on, and no strobe appears after re-enabling.
- R9: A change of the delay setting applies only to events sampled after the write edge. An event sampled at the same edge as the write uses the old setting.
- R10: If an event is sampled at the edge where a running count expires, the expiring strobe is still issued and a new count of N+1 starts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| panel_last_edge | input | 1 | One-cycle mark: last panel clock of the line has risen |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| line_end | output | 1 | Line-end strobe |

## Verification
Two functions can collide in one cycle:
- Event and expiry. A line-end event can be sampled at the very edge where a running count expires. The bench raises the event indication one cycle before the expected strobe. It then requires two strobes: one at the original time and one N+1 cycles later.
- Event and write. A control write can land on the same edge as an event. The bench checks that the event is timed with the old delay setting. It also checks that an event coinciding with an enable write is dropped.

// File: rtl/lep_pkg.sv
package lep_pkg;
   localparam int LEP_DATA_W  = 32;
   localparam int LEP_DELAY_W = 7;
   localparam int LEP_EN_BIT  = 16;

   function automatic logic lep_writable(input int bit_idx, input int delay_w, input int en_bit);
      return (bit_idx < delay_w) || (bit_idx == en_bit);
   endfunction
endpackage

// File: rtl/lep_regs.sv
module lep_regs
   import lep_pkg::*;
#(
   parameter int DATA_W  = LEP_DATA_W,
   parameter int DELAY_W = LEP_DELAY_W,
   parameter int EN_BIT  = LEP_EN_BIT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic [DELAY_W-1:0] delay_q,
   output logic               en_q
);
   logic [DATA_W-1:0] ctrl_q;

   if (DELAY_W < 1 || DELAY_W > EN_BIT) begin : g_bad_delay
      $error("lep_regs: DELAY_W must be in 1..EN_BIT");
   end
   if (EN_BIT >= DATA_W) begin : g_bad_en
      $error("lep_regs: EN_BIT must lie inside the data word");
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (lep_writable(i, DELAY_W, EN_BIT)) begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ctrl_q[i] <= 1'b0;
            else if (wr_en) ctrl_q[i] <= wr_data[i];
         end
      end else begin : g_rsvd
         assign ctrl_q[i] = 1'b0;
      end
   end

   assign rd_data = ctrl_q;
   assign delay_q = ctrl_q[DELAY_W-1:0];
   assign en_q    = ctrl_q[EN_BIT];

   // R2: a write shows up on the read port in the following cycle
   p_write_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (delay_q == $past(wr_data[DELAY_W-1:0])) && (en_q == $past(wr_data[EN_BIT])));
endmodule

// File: rtl/lep_delay.sv
module lep_delay #(
   parameter int DELAY_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               last_edge,
   input  logic [DELAY_W-1:0] delay,
   output logic               fire
);
   logic               busy_q;
   logic [DELAY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!en) begin
         busy_q <= 1'b0;
      end else if (last_edge) begin
         busy_q <= 1'b1;
         cnt_q  <= delay;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign fire = en && busy_q && (cnt_q == '0);

   // R7, R9: an accepted event loads the setting held before the edge
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && last_edge) |=> busy_q && (cnt_q == $past(delay)));
   // R4: a running count steps down by one each cycle
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy_q && !last_edge && cnt_q != '0) |=> busy_q && (cnt_q == $past(cnt_q) - 1'b1));
   // R8: a disabled counter holds nothing pending
   p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy_q || $past(en));
endmodule

// File: rtl/lep_shaper.sv
module lep_shaper (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fire,
   output logic pulse
);
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= fire && en;
   end

   assign pulse = pulse_q && en;

   // R4: a count reaching zero produces the strobe in the next cycle
   p_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && en) |=> pulse || !en);
   // R6: no strobe while disabled
   p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pulse);
endmodule

// File: rtl/line_end_gen.sv
module line_end_gen
   import lep_pkg::*;
#(
   parameter int DATA_W  = LEP_DATA_W,
   parameter int DELAY_W = LEP_DELAY_W,
   parameter int EN_BIT  = LEP_EN_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              panel_last_edge,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              line_end
);
   logic [DELAY_W-1:0] delay_s;
   logic               en_s;
   logic               fire_s;

   lep_regs #(.DATA_W(DATA_W), .DELAY_W(DELAY_W), .EN_BIT(EN_BIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_data(reg_wdata),
      .rd_data(reg_rdata), .delay_q(delay_s), .en_q(en_s)
   );

   lep_delay #(.DELAY_W(DELAY_W)) u_delay (
      .clk(clk), .rst_n(rst_n), .en(en_s), .last_edge(panel_last_edge),
      .delay(delay_s), .fire(fire_s)
   );

   lep_shaper u_shaper (
      .clk(clk), .rst_n(rst_n), .en(en_s), .fire(fire_s), .pulse(line_end)
   );

   // R3: reserved bits never read as one
   p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> $countones(reg_rdata) <= DELAY_W + 1);
endmodule

// File: tb/sim_line_end_gen.sv
module sim_line_end_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        panel_last_edge = 1'b0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        line_end;
   int checks = 0;
   int failures = 0;
   logic done = 1'b0;

   localparam logic [31:0] EN = 32'h0001_0000;

   line_end_gen u0 (.clk(clk), .rst_n(rst_n), .panel_last_edge(panel_last_edge),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_end(line_end));

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   // fires one event; on return we are at the negedge right after the sampling edge (j=0)
   task automatic event_now();
      @(negedge clk); panel_last_edge = 1'b1;
      @(negedge clk); panel_last_edge = 1'b0;
   endtask

   // watch LEN negedges; returns first j with line_end high (0 if none) and high count
   task automatic watch(input int len, output int first, output int highs);
      first = 0; highs = 0;
      for (int j = 1; j <= len; j++) begin
         @(negedge clk);
         if (line_end) begin
            highs++;
            if (first == 0) first = j;
         end
      end
   endtask

   task automatic t_reset();
      chk("R1 rdata", reg_rdata, 32'h0);
      chk("R1 line_end", {31'b0, line_end}, 32'h0);
   endtask

   task automatic t_regs();
      wr(32'hFFFF_FFFF);
      chk("R3 all-ones read", reg_rdata, 32'h0001_007F);
      wr(32'h0001_0025);
      chk("R2 readback", reg_rdata, 32'h0001_0025);
      wr(32'hFFFE_FF80);
      chk("R3 reserved only", reg_rdata, 32'h0);
   endtask

   task automatic t_delay(input int n);
      int f, h;
      wr(EN | n);
      event_now();
      watch(n + 6, f, h);
      chk($sformatf("R4 delay N=%0d", n), f, n + 1);
      chk("R5 one cycle", h, 1);
   endtask

   task automatic t_disabled();
      int f, h;
      wr(32'h0000_0003);
      event_now();
      watch(10, f, h);
      chk("R6 disabled ignores", h, 0);
      // enable written on same edge as an event
      @(negedge clk); reg_we = 1'b1; reg_wdata = EN | 3; panel_last_edge = 1'b1;
      @(negedge clk); reg_we = 1'b0; panel_last_edge = 1'b0;
      watch(10, f, h);
      chk("R6 event at enable edge", h, 0);
   endtask

   task automatic t_restart();
      int f, h;
      wr(EN | 5);
      event_now();
      repeat (2) @(negedge clk);
      event_now();
      watch(12, f, h);
      chk("R7 restart timing", f, 6);
      chk("R7 single strobe", h, 1);
   endtask

   task automatic t_cancel();
      int f, h;
      wr(EN | 10);
      event_now();
      repeat (3) @(negedge clk);
      wr(32'h0000_000A);
      chk("R8 low after disable", {31'b0, line_end}, 32'h0);
      watch(15, f, h);
      chk("R8 no strobe while off", h, 0);
      wr(EN | 10);
      watch(15, f, h);
      chk("R8 nothing after re-enable", h, 0);
   endtask

   task automatic t_change();
      int f, h;
      wr(EN | 4);
      // write new delay on same edge as event: old setting 4 applies
      @(negedge clk); reg_we = 1'b1; reg_wdata = EN | 9; panel_last_edge = 1'b1;
      @(negedge clk); reg_we = 1'b0; panel_last_edge = 1'b0;
      watch(14, f, h);
      chk("R9 same-edge uses old", f, 5);
      // write during count does not alter it
      wr(EN | 2);
      event_now();
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = EN | 20;
      @(negedge clk); reg_we = 1'b0;
      watch(25, f, h);
      chk("R9 mid-count write ignored", f, 1);
      event_now();
      watch(25, f, h);
      chk("R9 new value for next event", f, 21);
   endtask

   task automatic t_collide();
      int h;
      int hi_at4, hi_at8;
      wr(EN | 3);
      event_now();
      h = 0; hi_at4 = 0; hi_at8 = 0;
      for (int j = 1; j <= 12; j++) begin
         @(negedge clk);
         if (line_end) begin
            h++;
            if (j == 4) hi_at4 = 1;
            if (j == 8) hi_at8 = 1;
         end
         panel_last_edge = (j == 3);
      end
      chk("R10 expiring strobe kept", hi_at4, 1);
      chk("R10 new count strobe", hi_at8, 1);
      chk("R10 strobe count", h, 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_delay(0);
      t_delay(1);
      t_delay(7);
      t_delay(127);
      t_disabled();
      t_restart();
      t_cancel();
      t_change();
      t_collide();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule